// File: doc/BRIEF.md
# Serial Receiver Interrupt Enable and Identification Registers

This block is the interrupt side of a serial receiver's register file. A byte that has already been deserialised arrives on `rx_byte` with a one-cycle `rx_valid` strobe. The block keeps that byte in a receive holding register and sets a data-ready flag. A host reaches three byte-wide registers at consecutive I/O addresses starting at `BASE_ADDR`, which defaults to 0x3F8:

- offset 0 is the receive holding register;
- offset 1 is the interrupt enable register;
- offset 2 is the interrupt identification register.

The identification code is built like this. Bit 0 is an active-low "interrupt pending" flag, and bits 2:1 give the source. Only the received-data source (bits 2:1 = 2'b10) exists here, so the register reads 0x04 while the enabled condition is pending and 0x01 at all other times. Reading the identification register has no side effect. Only a read of the receive holding register clears the data-ready flag. The `irq` output is the data-ready flag ANDed with enable bit 0, so software that masks the source drops the line at once.

Reads are combinational. While `io_rd` is high, `io_rdata` shows the addressed register. Side effects of a read or a write take hold at the rising clock edge where the strobe is sampled.

Top module: `uart_rx_irq_regs`

## Requirements
- R1: After reset the enable register (offset 1) reads 0x00, the identification register (offset 2) reads 0x01, and `irq` is low.
- R2: A write to offset 1 stores bit 0 as the received-data interrupt enable. The enable register reads back that bit, and bits 7:1 always read 0.
- R3: A byte strobed in by `rx_valid` is held, and a read of offset 0 returns it until the next byte arrives.
- R4: With the enable set, the cycle after a `rx_valid` strobe shows `irq` high and offset 2 reading 0x04.
- R5: Repeated reads of offset 2 while the condition is pending keep returning 0x04 and leave `irq` high.
- R6: A read of offset 0 clears the data-ready flag. From the next cycle offset 2 reads 0x01 and `irq` is low.
- R7: Clearing enable bit 0 lowers `irq` in the next cycle while data stays ready. Setting bit 0 again raises `irq` in the next cycle.
- R8: A byte that arrives before the holding register is read overwrites it, and the condition stays pending.
- R9: A byte received while the enable is clear sets data-ready. In that state offset 2 reads 0x01, and a later write of 0x01 to offset 1 raises `irq` in the next cycle.
- R10: If `rx_valid` and a read of offset 0 fall in the same cycle, the read returns the old byte, the new byte is stored, and data-ready stays set.
- R11: Reads outside the three addresses return 0x00, `io_rdata` is 0x00 whenever `io_rd` is low, and writes to offsets 0 and 2 or outside the range change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_byte | input | 8 | Deserialised received byte |
| rx_valid | input | 1 | One-cycle strobe that `rx_byte` is valid |
| io_addr | input | 16 | Host I/O address |
| io_rd | input | 1 | Host read strobe |
| io_wr | input | 1 | Host write strobe |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Host read data (combinational) |
| irq | output | 1 | Interrupt request, active high |

## Verification
A data-ready flag that is stuck or cleared by the wrong access shows up at once. `irq` or the identification code at offset 2 is then wrong in the cycle after the strobe, the read or the enable write that should have changed it. A lost or stale holding byte shows only on the next read of offset 0. The bench therefore reads offset 0 after each overwrite and after the collision case. A wrong decode of the enable bit shows on the readback of offset 1 and on the `irq` level in the following cycle.

// File: rtl/uart_rx_irq_pkg.sv
// Package: shared register offsets and identification codes for the
// serial receiver interrupt register block. Assumes a byte-wide data bus.
package uart_rx_irq_pkg;

    localparam int DATA_W   = 8;
    localparam int NUM_REGS = 3;

    // Register offsets relative to the base address
    localparam logic [1:0] OFF_RBUF  = 2'd0;
    localparam logic [1:0] OFF_IEN   = 2'd1;
    localparam logic [1:0] OFF_IDENT = 2'd2;

    // Identification source field (bits 2:1)
    typedef enum logic [1:0] {
        SRC_NONE  = 2'b00,
        SRC_RXDAT = 2'b10
    } irq_src_e;

    // Build an identification code from its pending flag and source
    function automatic logic [DATA_W-1:0] ident_code(input logic pend, input irq_src_e src);
        logic [DATA_W-1:0] c;
        c      = '0;
        c[0]   = ~pend;
        c[2:1] = pend ? src : SRC_NONE;
        return c;
    endfunction

endpackage

// File: rtl/uart_rx_irq_decode.sv
// Module: address decoder. Produces one-hot read and write selects for
// the register slots at BASE_ADDR + k. Assumes strobes are single-cycle
// qualified by the caller's clock.
module uart_rx_irq_decode #(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] BASE_ADDR = 16'h03F8,
    parameter int          NUM_REGS  = 3
) (
    input  logic [ADDR_W-1:0]   io_addr,
    input  logic                io_rd,
    input  logic                io_wr,
    output logic [NUM_REGS-1:0] rd_sel,
    output logic [NUM_REGS-1:0] wr_sel
);

    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_ADDR);

    // One comparator per register slot
    for (genvar k = 0; k < NUM_REGS; k++) begin : g_slot
        logic hit;
        always_comb begin
            // Purpose: match the address against slot k
            hit       = (io_addr == BASE + ADDR_W'(k));
            rd_sel[k] = hit & io_rd;
            wr_sel[k] = hit & io_wr;
        end
    end

endmodule

// File: rtl/uart_rx_irq_rbuf.sv
// Module: receive holding register and data-ready flag. A new byte
// always wins over a simultaneous clearing read, so no byte is lost.
module uart_rx_irq_rbuf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              rx_valid,
    input  logic              rd_clr,
    output logic [DATA_W-1:0] rbuf_q,
    output logic              ready_q
);

    // Purpose: capture received bytes and track data-ready
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbuf_q  <= '0;
            ready_q <= 1'b0;
        end else if (rx_valid) begin
            rbuf_q  <= rx_byte;
            ready_q <= 1'b1;
        end else if (rd_clr) begin
            ready_q <= 1'b0;
        end
    end

endmodule

// File: rtl/uart_rx_irq_ien.sv
// Module: interrupt enable register. Only bit 0 (received data) is
// implemented; other bits read as zero.
module uart_rx_irq_ien #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic              en_q,
    output logic [DATA_W-1:0] rd_val
);

    // Purpose: hold the received-data interrupt enable
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= 1'b0;
        else if (wr_en)
            en_q <= wdata[0];
    end

    // Purpose: readback with unimplemented bits at zero
    always_comb begin
        rd_val    = '0;
        rd_val[0] = en_q;
    end

endmodule

// File: rtl/uart_rx_irq_ident.sv
// Module: interrupt identification and request. Purely combinational
// from the data-ready flag and the enable; reading it has no effect.
module uart_rx_irq_ident
    import uart_rx_irq_pkg::*;
#(
    parameter int ID_W = 8
) (
    input  logic            ready,
    input  logic            en,
    output logic [ID_W-1:0] ident,
    output logic            irq
);

    logic pend;

    // Purpose: form pending condition, identification code and request
    always_comb begin
        pend  = ready & en;
        ident = ID_W'(ident_code(pend, SRC_RXDAT));
        irq   = pend;
    end

endmodule

// File: rtl/uart_rx_irq_regs.sv
// Module: top of the serial receiver interrupt register block. Assumes
// bytes arrive already deserialised and the host uses single-cycle
// read and write strobes; read data is combinational.
module uart_rx_irq_regs
    import uart_rx_irq_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] BASE_ADDR = 16'h03F8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              rx_valid,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    output logic              irq
);

    logic [NUM_REGS-1:0] rd_sel;
    logic [NUM_REGS-1:0] wr_sel;
    logic [DATA_W-1:0]   rbuf_q;
    logic                data_ready;
    logic                ien_q;
    logic [DATA_W-1:0]   ien_rd;
    logic [DATA_W-1:0]   ident_rd;

    uart_rx_irq_decode #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR),
        .NUM_REGS  (NUM_REGS)
    ) u_decode (
        .io_addr (io_addr),
        .io_rd   (io_rd),
        .io_wr   (io_wr),
        .rd_sel  (rd_sel),
        .wr_sel  (wr_sel)
    );

    uart_rx_irq_rbuf #(.DATA_W(DATA_W)) u_rbuf (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_byte  (rx_byte),
        .rx_valid (rx_valid),
        .rd_clr   (rd_sel[OFF_RBUF]),
        .rbuf_q   (rbuf_q),
        .ready_q  (data_ready)
    );

    uart_rx_irq_ien #(.DATA_W(DATA_W)) u_ien (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_sel[OFF_IEN]),
        .wdata  (io_wdata),
        .en_q   (ien_q),
        .rd_val (ien_rd)
    );

    uart_rx_irq_ident #(.ID_W(DATA_W)) u_ident (
        .ready (data_ready),
        .en    (ien_q),
        .ident (ident_rd),
        .irq   (irq)
    );

    // Purpose: read data mux, zero when no slot is selected
    always_comb begin
        io_rdata = '0;
        unique case (1'b1)
            rd_sel[OFF_RBUF]:  io_rdata = rbuf_q;
            rd_sel[OFF_IEN]:   io_rdata = ien_rd;
            rd_sel[OFF_IDENT]: io_rdata = ident_rd;
            default:           io_rdata = '0;
        endcase
    end

endmodule

// File: rtl/uart_rx_irq_chk.sv
// Module: assertion checker for uart_rx_irq_regs, attached by bind.
module uart_rx_irq_chk #(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] BASE_ADDR = 16'h03F8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [7:0]        rx_byte,
    input logic              rx_valid,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_rd,
    input logic              io_wr,
    input logic [7:0]        io_wdata,
    input logic [7:0]        io_rdata,
    input logic              irq,
    input logic [7:0]        rbuf_q,
    input logic              data_ready,
    input logic              ien_q
);

    localparam logic [ADDR_W-1:0] A_RBUF  = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] A_IEN   = ADDR_W'(BASE_ADDR) + ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_IDENT = ADDR_W'(BASE_ADDR) + ADDR_W'(2);

    // R3
    rx_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> (rbuf_q == $past(rx_byte)) && data_ready);

    // R4
    pend_ident_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_addr == A_IDENT && data_ready && ien_q) |-> (io_rdata == 8'h04 && irq));

    // R5
    ident_read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_addr == A_IDENT && !rx_valid) |=> $stable(data_ready) && $stable(rbuf_q));

    // R6
    rbuf_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_addr == A_RBUF && !rx_valid) |=> !data_ready && !irq);

    // R7
    mask_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == A_IEN && !io_wdata[0]) |=> !irq);

    // R10
    collision_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && io_rd && io_addr == A_RBUF) |=> data_ready);

    // R11
    idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |-> io_rdata == 8'h00);

endmodule

bind uart_rx_irq_regs uart_rx_irq_chk #(
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_byte    (rx_byte),
    .rx_valid   (rx_valid),
    .io_addr    (io_addr),
    .io_rd      (io_rd),
    .io_wr      (io_wr),
    .io_wdata   (io_wdata),
    .io_rdata   (io_rdata),
    .irq        (irq),
    .rbuf_q     (rbuf_q),
    .data_ready (data_ready),
    .ien_q      (ien_q)
);

// File: tb/test_uart_rx_irq_regs.sv
// Bench for uart_rx_irq_regs: a vector table walked by one loop, then
// directed tests for reset, decode range and the read/receive collision.
module test_uart_rx_irq_regs;

    localparam logic [15:0] BASE = 16'h03F8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_valid = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    uart_rx_irq_regs i_uart_rx_irq_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_byte  (rx_byte),
        .rx_valid (rx_valid),
        .io_addr  (io_addr),
        .io_rd    (io_rd),
        .io_wr    (io_wr),
        .io_wdata (io_wdata),
        .io_rdata (io_rdata),
        .irq      (irq)
    );

    // Vector: {req[3:0], op[1:0], off[1:0], data[7:0], exp_rd[7:0], exp_irq}
    // op 0 = host read, 1 = host write, 2 = receive byte
    localparam int NV = 18;
    localparam logic [24:0] VEC [NV] = '{
        {4'd1,  2'd0, 2'd1, 8'h00, 8'h00, 1'b0},  // R1 enable reads 0
        {4'd1,  2'd0, 2'd2, 8'h00, 8'h01, 1'b0},  // R1 ident idle
        {4'd2,  2'd1, 2'd1, 8'hFF, 8'h00, 1'b0},  // R2 enable with all bits
        {4'd2,  2'd0, 2'd1, 8'h00, 8'h01, 1'b0},  // R2 only bit 0 reads back
        {4'd4,  2'd2, 2'd0, 8'h5A, 8'h00, 1'b1},  // R4 byte raises irq
        {4'd5,  2'd0, 2'd2, 8'h00, 8'h04, 1'b1},  // R5 first ident read
        {4'd5,  2'd0, 2'd2, 8'h00, 8'h04, 1'b1},  // R5 repeat ident read
        {4'd8,  2'd2, 2'd0, 8'hC3, 8'h00, 1'b1},  // R8 overwrite
        {4'd8,  2'd0, 2'd0, 8'h00, 8'hC3, 1'b0},  // R8 newer byte, R6 clear
        {4'd6,  2'd0, 2'd2, 8'h00, 8'h01, 1'b0},  // R6 ident back to idle
        {4'd7,  2'd1, 2'd1, 8'h00, 8'h00, 1'b0},  // R7 disable
        {4'd9,  2'd2, 2'd0, 8'h11, 8'h00, 1'b0},  // R9 byte while disabled
        {4'd9,  2'd0, 2'd2, 8'h00, 8'h01, 1'b0},  // R9 ident idle while masked
        {4'd9,  2'd1, 2'd1, 8'h01, 8'h00, 1'b1},  // R9 enable raises irq
        {4'd7,  2'd1, 2'd1, 8'h00, 8'h00, 1'b0},  // R7 mask drops irq
        {4'd7,  2'd1, 2'd1, 8'h01, 8'h00, 1'b1},  // R7 unmask raises irq
        {4'd11, 2'd1, 2'd0, 8'h99, 8'h00, 1'b1},  // R11 write to buffer ignored
        {4'd3,  2'd0, 2'd0, 8'h00, 8'h11, 1'b0}   // R3 held byte returned
    };

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic check1(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    // Drive one operation, sample read data before the edge, irq after it
    task automatic do_op(input logic [1:0] op, input logic [15:0] addr,
                         input logic [7:0] data, output logic [7:0] rd,
                         output logic irq_after);
        @(negedge clk);
        io_addr  = addr;
        io_rd    = (op == 2'd0);
        io_wr    = (op == 2'd1);
        io_wdata = data;
        rx_valid = (op == 2'd2);
        rx_byte  = data;
        #1;
        rd = io_rdata;
        @(negedge clk);
        irq_after = irq;
        io_rd    = 1'b0;
        io_wr    = 1'b0;
        rx_valid = 1'b0;
    endtask

    initial begin : watchdog
        #500000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        logic [7:0] rd;
        logic       ia;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 irq low and rdata idle after reset
        check1("R1 irq after reset", irq, 1'b0);
        check8("R11 rdata idle", io_rdata, 8'h00);

        for (int i = 0; i < NV; i++) begin
            logic [24:0] v;
            string       tag;
            v = VEC[i];
            do_op(v[20:19], BASE + 16'(v[18:17]), v[16:9], rd, ia);
            tag = $sformatf("R%0d vec %0d", v[24:21], i);
            if (v[20:19] == 2'd0)
                check8(tag, rd, v[8:1]);
            check1(tag, ia, v[0]);
        end

        // R11 reads outside the window return zero
        do_op(2'd0, BASE + 16'd3, 8'h00, rd, ia);
        check8("R11 read above range", rd, 8'h00);
        do_op(2'd0, BASE - 16'd1, 8'h00, rd, ia);
        check8("R11 read below range", rd, 8'h00);
        // R11 write outside the window leaves enable alone
        do_op(2'd1, BASE + 16'd1, 8'h00, rd, ia);
        do_op(2'd1, BASE + 16'd3, 8'h01, rd, ia);
        do_op(2'd0, BASE + 16'd1, 8'h00, rd, ia);
        check8("R11 enable after stray write", rd, 8'h00);
        // R11 write to ident is ignored
        do_op(2'd1, BASE + 16'd2, 8'hFF, rd, ia);
        do_op(2'd0, BASE + 16'd2, 8'h00, rd, ia);
        check8("R11 ident after write", rd, 8'h01);

        // R10 read of buffer colliding with a new byte
        do_op(2'd1, BASE + 16'd1, 8'h01, rd, ia);
        do_op(2'd2, BASE, 8'hAA, rd, ia);
        @(negedge clk);
        io_addr  = BASE;
        io_rd    = 1'b1;
        rx_valid = 1'b1;
        rx_byte  = 8'hBB;
        #1;
        check8("R10 collision read old byte", io_rdata, 8'hAA);
        @(negedge clk);
        io_rd    = 1'b0;
        rx_valid = 1'b0;
        check1("R10 irq stays after collision", irq, 1'b1);
        do_op(2'd0, BASE, 8'h00, rd, ia);
        check8("R10 new byte kept", rd, 8'hBB);
        check1("R6 irq cleared by read", ia, 1'b0);

        // R1 reset returns everything to idle
        do_op(2'd2, BASE, 8'h77, rd, ia);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check1("R1 irq after second reset", irq, 1'b0);
        do_op(2'd0, BASE + 16'd1, 8'h00, rd, ia);
        check8("R1 enable after second reset", rd, 8'h00);
        do_op(2'd0, BASE + 16'd2, 8'h00, rd, ia);
        check8("R1 ident after second reset", rd, 8'h01);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule